// File: doc/BRIEF.md
# Bus-to-Core Control Register Synchronizer

This block sits between a register bus running on a bus clock and a peripheral core running on its own, unrelated clock. Software writes an enable bit and a control word on the bus side; the block carries each value into the core domain through its own toggle handshake and raises a per-item busy flag in a read-only status word until the core side has taken the value. While a flag is set, further writes to that item are dropped. Bus reads of the control registers return the last accepted value at once, not the core-side copy.

A software reset bit clears itself on the bus side one cycle after it is written. Its busy flag stays up until the core has held its own reset for a fixed number of core clocks and has answered. While that flag is set, every access other than the software reset itself is refused. Once the answer arrives, all bus-side registers return to zero. A bank of static configuration registers has no handshake. It can be written only while the enable bit is clear. Every bus transfer completes with zero wait states, even when the core clock is stopped. Polling the status word is the only way to learn that a transfer has completed.

Top module: `xdom_reg_sync`

## Requirements
- R1: The status word at offset 0xE8 reads zero after reset; bit 0 is the software-reset busy flag, bit 1 the enable busy flag, bit 2 the control-word busy flag, and bits 31..3 always read zero.
- R2: A write to the control word (offset 0x04) while its busy flag is set is ignored: bus readback and the core copy keep the earlier value.
- R3: A write to the enable bit (offset 0x00, bit 1) while the enable busy flag is set is ignored.
- R4: An accepted control-word or enable write sets its busy flag on the next bus cycle, and the flag clears only after the core output carries the written value.
- R5: Writing 1 to bit 0 at offset 0x00 starts a software reset; that bit reads back as 0 from the cycle after the write.
- R6: The software-reset busy flag stays set until the core-side reset output has been high for RST_HOLD core clocks (default 4, at least 2) and the acknowledge has returned.
- R7: While the software-reset busy flag is set, writes to the control word, the enable bit and the configuration bank are refused. Reads of every address except the status word and offset 0x00 return zero, and offset 0x00 reads the enable bit as 0.
- R8: When a software reset completes, the enable bit, the control word, every configuration register and both core outputs are zero.
- R9: Configuration register i sits at offset 0x20+4*i (10 registers, 16 bits). A write is ignored while the enable bit reads 1, and it is taken when the enable bit is 0.
- R10: Reads of the enable bit and the control word return the last accepted bus value immediately, before the core copy is updated.
- R11: With the core clock stopped, bus transfers still complete with no stall, and the busy flags of pending writes stay set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| prst | input | 1 | Bus-domain synchronous reset, active high |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data, registered in the setup phase |
| cclk | input | 1 | Core clock |
| crst | input | 1 | Core-domain synchronous reset, active high |
| core_en | output | 1 | Enable bit as seen in the core domain |
| core_ctrlb | output | CTRLB_W | Control word as seen in the core domain |
| core_srst | output | 1 | Core-domain software reset pulse |
| cfg_flat | output | NCFG*CFG_W | Configuration bank, register i in bits [i*CFG_W +: CFG_W] |

## Verification
The assertions check several rules on every cycle. Refused writes to a busy item, to the configuration bank while enabled, or to anything during software reset must leave the register unchanged. The reset bit must fall one cycle after it rises. Reads refused during reset must return zero, and an acknowledge may only move while its item is busy. The core reset pulse must be at least two core cycles long. The bench scenarios are needed for the end-to-end behaviour: a value actually arriving in the core, the exact length of the reset pulse, all registers clearing when the reset finishes, and the flags staying set while the bench holds the core clock stopped.

// File: rtl/xrs_pkg.sv
package xrs_pkg;
  // Status word layout, most significant field first: bit2 ctrl word, bit1 enable, bit0 reset
  typedef struct packed {
    logic cb_busy;
    logic en_busy;
    logic srst_busy;
  } sync_status_t;
endpackage

// File: rtl/xrs_sync2.sv
module xrs_sync2 #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/xrs_xfer_item.sv
module xrs_xfer_item #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         b_clk,
  input  logic         b_rst,
  input  logic         b_start,
  input  logic [W-1:0] b_wdata,
  output logic         b_busy,
  input  logic         c_clk,
  input  logic         c_rst,
  input  logic         c_clr,
  output logic [W-1:0] c_q
);
  logic         req_t, busy_q, ack_s;
  logic [W-1:0] hold_q;
  logic         req_s, req_seen;

  // bus side: the held value stays stable while the request is outstanding
  always_ff @(posedge b_clk) begin
    if (b_rst) begin
      req_t  <= 1'b0;
      busy_q <= 1'b0;
      hold_q <= '0;
    end else if (b_start) begin
      req_t  <= ~req_t;
      hold_q <= b_wdata;
      busy_q <= 1'b1;
    end else if (busy_q && (ack_s == req_t)) begin
      busy_q <= 1'b0;
    end
  end

  assign b_busy = busy_q;

  xrs_sync2 #(.STAGES(STAGES)) u_req_sync (
    .clk(c_clk), .rst(c_rst), .d(req_t), .q(req_s)
  );

  // core side: capture on a new toggle; the seen toggle doubles as acknowledge
  always_ff @(posedge c_clk) begin
    if (c_rst) req_seen <= 1'b0;
    else       req_seen <= req_s;
  end

  always_ff @(posedge c_clk) begin
    if (c_rst || c_clr)        c_q <= '0;
    else if (req_s != req_seen) c_q <= hold_q;
  end

  xrs_sync2 #(.STAGES(STAGES)) u_ack_sync (
    .clk(b_clk), .rst(b_rst), .d(req_seen), .q(ack_s)
  );

  assert_ack_moves_only_busy_R4: assert property (@(posedge b_clk) disable iff (b_rst)
    (ack_s != $past(ack_s)) |-> $past(busy_q));
endmodule

// File: rtl/xrs_srst_item.sv
module xrs_srst_item #(
  parameter int HOLD   = 4,
  parameter int STAGES = 2
) (
  input  logic b_clk,
  input  logic b_rst,
  input  logic b_start,
  output logic b_busy,
  output logic b_done,
  input  logic c_clk,
  input  logic c_rst,
  output logic c_rst_o
);
  localparam int CW = $clog2(HOLD + 1);

  logic          req_t, busy_q, ack_s;
  logic          req_s, req_seen, active, ack_t;
  logic [CW-1:0] cnt;

  always_ff @(posedge b_clk) begin
    if (b_rst) begin
      req_t  <= 1'b0;
      busy_q <= 1'b0;
    end else if (b_start) begin
      req_t  <= ~req_t;
      busy_q <= 1'b1;
    end else if (b_done) begin
      busy_q <= 1'b0;
    end
  end

  assign b_busy = busy_q;
  assign b_done = busy_q && (ack_s == req_t);

  xrs_sync2 #(.STAGES(STAGES)) u_req_sync (
    .clk(c_clk), .rst(c_rst), .d(req_t), .q(req_s)
  );

  // core side: hold reset for HOLD cycles, then answer
  always_ff @(posedge c_clk) begin
    if (c_rst) begin
      req_seen <= 1'b0;
      active   <= 1'b0;
      cnt      <= '0;
      ack_t    <= 1'b0;
    end else begin
      req_seen <= req_s;
      if (req_s != req_seen) begin
        active <= 1'b1;
        cnt    <= CW'(HOLD);
      end else if (cnt > CW'(1)) begin
        cnt <= cnt - CW'(1);
      end else if (active) begin
        active <= 1'b0;
        cnt    <= '0;
        ack_t  <= req_seen;
      end
    end
  end

  assign c_rst_o = active;

  xrs_sync2 #(.STAGES(STAGES)) u_ack_sync (
    .clk(b_clk), .rst(b_rst), .d(ack_t), .q(ack_s)
  );

  assert_busy_until_ack_R6: assert property (@(posedge b_clk) disable iff (b_rst)
    (busy_q && (ack_s != req_t)) |=> busy_q);

  assert_core_pulse_min_R6: assert property (@(posedge c_clk) disable iff (c_rst)
    $fell(active) |-> $past(active, 2));
endmodule

// File: rtl/xdom_reg_sync.sv
module xdom_reg_sync #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int CTRLB_W     = 8,
  parameter int CFG_W       = 16,
  parameter int NCFG        = 10,
  parameter int SYNC_STAGES = 2,
  parameter int RST_HOLD    = 4,
  parameter logic [ADDR_W-1:0] CTRLA_OFS  = 8'h00,
  parameter logic [ADDR_W-1:0] CTRLB_OFS  = 8'h04,
  parameter logic [ADDR_W-1:0] CFG_OFS    = 8'h20,
  parameter logic [ADDR_W-1:0] STATUS_OFS = 8'hE8
) (
  input  logic                  pclk,
  input  logic                  prst,
  input  logic                  psel,
  input  logic                  penable,
  input  logic                  pwrite,
  input  logic [ADDR_W-1:0]     paddr,
  input  logic [DATA_W-1:0]     pwdata,
  output logic [DATA_W-1:0]     prdata,
  input  logic                  cclk,
  input  logic                  crst,
  output logic                  core_en,
  output logic [CTRLB_W-1:0]    core_ctrlb,
  output logic                  core_srst,
  output logic [NCFG*CFG_W-1:0] cfg_flat
);
  import xrs_pkg::*;

  localparam int SW = $bits(sync_status_t);

  logic wr_acc, rd_setup;
  logic hit_a, hit_b, hit_st;
  logic [NCFG-1:0] cfg_sel;

  logic srst_busy, srst_done, en_busy, cb_busy;
  logic srst_start, en_start, cb_start;
  logic srst_bit_q, en_q;
  logic [CTRLB_W-1:0] cb_q;
  logic [NCFG-1:0][CFG_W-1:0] cfg_q;
  logic [DATA_W-1:0] rd_next;
  logic core_clr;
  sync_status_t status;

  assign wr_acc   = psel && penable && pwrite;
  assign rd_setup = psel && !penable && !pwrite;
  assign hit_a    = (paddr == CTRLA_OFS);
  assign hit_b    = (paddr == CTRLB_OFS);
  assign hit_st   = (paddr == STATUS_OFS);

  for (genvar i = 0; i < NCFG; i++) begin : g_dec
    assign cfg_sel[i] = (paddr == CFG_OFS + ADDR_W'(4 * i));
  end

  // acceptance rules
  assign srst_start = wr_acc && hit_a && pwdata[0] && !srst_busy;
  assign en_start   = wr_acc && hit_a && !pwdata[0] && !srst_busy && !en_busy;
  assign cb_start   = wr_acc && hit_b && !srst_busy && !cb_busy;

  always_ff @(posedge pclk) begin
    if (prst) srst_bit_q <= 1'b0;
    else      srst_bit_q <= srst_start;
  end

  always_ff @(posedge pclk) begin
    if (prst || srst_done) begin
      en_q <= 1'b0;
      cb_q <= '0;
    end else begin
      if (en_start) en_q <= pwdata[1];
      if (cb_start) cb_q <= pwdata[CTRLB_W-1:0];
    end
  end

  for (genvar i = 0; i < NCFG; i++) begin : g_cfg
    always_ff @(posedge pclk) begin
      if (prst || srst_done)
        cfg_q[i] <= '0;
      else if (wr_acc && cfg_sel[i] && !srst_busy && !en_q)
        cfg_q[i] <= pwdata[CFG_W-1:0];
    end
  end

  assign cfg_flat = cfg_q;
  assign status   = '{cb_busy: cb_busy, en_busy: en_busy, srst_busy: srst_busy};

  always_comb begin
    rd_next = '0;
    if (hit_st)
      rd_next = DATA_W'(status);
    else if (hit_a)
      rd_next = DATA_W'({en_q && !srst_busy, srst_bit_q});
    else if (hit_b && !srst_busy)
      rd_next = DATA_W'(cb_q);
    else if (!srst_busy)
      for (int i = 0; i < NCFG; i++)
        if (cfg_sel[i]) rd_next = DATA_W'(cfg_q[i]);
  end

  always_ff @(posedge pclk) begin
    if (prst)          prdata <= '0;
    else if (rd_setup) prdata <= rd_next;
  end

  // cross-domain items
  xrs_srst_item #(.HOLD(RST_HOLD), .STAGES(SYNC_STAGES)) u_srst (
    .b_clk(pclk), .b_rst(prst), .b_start(srst_start), .b_busy(srst_busy),
    .b_done(srst_done), .c_clk(cclk), .c_rst(crst), .c_rst_o(core_srst)
  );

  assign core_clr = core_srst;

  xrs_xfer_item #(.W(1), .STAGES(SYNC_STAGES)) u_en (
    .b_clk(pclk), .b_rst(prst), .b_start(en_start), .b_wdata(pwdata[1:1]),
    .b_busy(en_busy), .c_clk(cclk), .c_rst(crst), .c_clr(core_clr), .c_q(core_en)
  );

  xrs_xfer_item #(.W(CTRLB_W), .STAGES(SYNC_STAGES)) u_cb (
    .b_clk(pclk), .b_rst(prst), .b_start(cb_start), .b_wdata(pwdata[CTRLB_W-1:0]),
    .b_busy(cb_busy), .c_clk(cclk), .c_rst(crst), .c_clr(core_clr), .c_q(core_ctrlb)
  );

  logic unused_wdata;
  assign unused_wdata = ^pwdata[DATA_W-1:CFG_W];

  // assertions
  assert_status_high_zero_R1: assert property (@(posedge pclk) disable iff (prst)
    (rd_setup && hit_st) |=> (prdata[DATA_W-1:SW] == '0));

  assert_cb_busy_drop_R2: assert property (@(posedge pclk) disable iff (prst)
    (wr_acc && hit_b && cb_busy && !srst_done) |=> $stable(cb_q));

  assert_en_busy_drop_R3: assert property (@(posedge pclk) disable iff (prst)
    (wr_acc && hit_a && en_busy && !srst_done) |=> $stable(en_q));

  assert_srst_self_clear_R5: assert property (@(posedge pclk) disable iff (prst)
    srst_bit_q |=> !srst_bit_q);

  assert_refused_read_zero_R7: assert property (@(posedge pclk) disable iff (prst)
    (rd_setup && srst_busy && !hit_a && !hit_st) |=> (prdata == '0));

  assert_cb_locked_in_reset_R7: assert property (@(posedge pclk) disable iff (prst)
    (wr_acc && srst_busy && !srst_done) |=> $stable(cb_q) && $stable(cfg_q));

  assert_clear_after_reset_R8: assert property (@(posedge pclk) disable iff (prst)
    srst_done |=> (!en_q && cb_q == '0 && cfg_q == '0));

  assert_cfg_locked_when_on_R9: assert property (@(posedge pclk) disable iff (prst)
    (wr_acc && (|cfg_sel) && en_q && !srst_done) |=> $stable(cfg_q));
endmodule

// File: tb/xdom_reg_sync_bench.sv
module xdom_reg_sync_bench;
  localparam logic [7:0] A_CTRLA = 8'h00, A_CTRLB = 8'h04, A_CFG = 8'h20, A_STAT = 8'hE8;

  logic pclk = 1'b0, cclk = 1'b0, cclk_run = 1'b1;
  logic prst = 1'b1, crst = 1'b1;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic core_en, core_srst;
  logic [7:0] core_ctrlb;
  logic [159:0] cfg_flat;

  int nchk = 0, nfail = 0, pulse_len = 0;
  bit finished = 0;
  logic exp_en;
  logic [7:0] exp_cb;
  logic [15:0] exp_cfg [10];

  always #10 pclk = ~pclk;
  always #7 if (cclk_run) cclk = ~cclk;
  always @(posedge cclk) if (core_srst) pulse_len++;

  xdom_reg_sync u_xdom_reg_sync (
    .pclk(pclk), .prst(prst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .cclk(cclk), .crst(crst),
    .core_en(core_en), .core_ctrlb(core_ctrlb), .core_srst(core_srst), .cfg_flat(cfg_flat)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge pclk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge pclk); penable = 1;
    @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge pclk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge pclk); penable = 1; d = prdata;
    @(negedge pclk); psel = 0; penable = 0;
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] s;
    s = 32'hFFFF_FFFF;
    for (int k = 0; k < 300; k++) begin
      apb_rd(A_STAT, s);
      if (s == 0) break;
    end
    check(req, s, 32'h0);
  endtask

  function automatic logic [15:0] cfg_slice(input int i);
    return cfg_flat[i*16 +: 16];
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd4242));
    exp_en = 0; exp_cb = 0;
    for (int i = 0; i < 10; i++) exp_cfg[i] = 0;
    repeat (5) @(negedge pclk);
    prst = 0; crst = 0;
    repeat (3) @(negedge pclk);

    // R1 reset state
    apb_rd(A_STAT, r);  check("R1 status after reset", r, 32'h0);
    check("R1 core_en reset", {31'b0, core_en}, 32'h0);
    check("R1 core_ctrlb reset", {24'b0, core_ctrlb}, 32'h0);
    check("R1 core_srst reset", {31'b0, core_srst}, 32'h0);

    // R10 / R4 plain transfer
    apb_wr(A_CTRLB, 32'h5A);
    apb_rd(A_CTRLB, r); check("R10 ctrlb immediate readback", r, 32'h5A);
    wait_idle("R4 ctrlb busy clears");
    check("R4 core_ctrlb value", {24'b0, core_ctrlb}, 32'h5A);

    // R2 R3 R11 with core clock stopped
    cclk_run = 0;
    apb_wr(A_CTRLB, 32'h33);
    apb_rd(A_STAT, r); check("R4 ctrlb busy set", r, 32'h4);
    apb_wr(A_CTRLB, 32'h99);
    apb_rd(A_CTRLB, r); check("R2 busy write dropped", r, 32'h33);
    apb_wr(A_CTRLA, 32'h2);
    apb_rd(A_STAT, r); check("R1 both busy bits", r, 32'h6);
    apb_wr(A_CTRLA, 32'h0);
    apb_rd(A_CTRLA, r); check("R3 busy enable write dropped", r, 32'h2);
    repeat (50) @(negedge pclk);
    apb_rd(A_STAT, r); check("R11 flags hold with core clock stopped", r, 32'h6);
    check("R11 core copy untouched", {24'b0, core_ctrlb}, 32'h5A);
    cclk_run = 1;
    wait_idle("R4 flags clear after restart");
    check("R2 core_ctrlb keeps first", {24'b0, core_ctrlb}, 32'h33);
    check("R3 core_en keeps first", {31'b0, core_en}, 32'h1);
    exp_en = 1; exp_cb = 8'h33;

    // R9 protection
    apb_wr(A_CFG + 8'd12, 32'h1234);
    apb_rd(A_CFG + 8'd12, r); check("R9 cfg write while enabled ignored", r, 32'h0);
    check("R9 cfg output untouched", {16'b0, cfg_slice(3)}, 32'h0);
    apb_wr(A_CTRLA, 32'h0); wait_idle("R4 disable"); exp_en = 0;
    apb_wr(A_CFG + 8'd12, 32'h1234); exp_cfg[3] = 16'h1234;
    apb_rd(A_CFG + 8'd12, r); check("R9 cfg write while disabled taken", r, 32'h1234);
    check("R9 cfg output", {16'b0, cfg_slice(3)}, 32'h1234);

    // random mix
    for (int n = 0; n < 150; n++) begin
      int op, idx;
      logic [31:0] d;
      op = int'($urandom % 4); idx = int'($urandom % 10); d = $urandom;
      case (op)
        0: begin
          apb_wr(A_CTRLB, d); exp_cb = d[7:0];
          apb_rd(A_CTRLB, r); check("R10 random ctrlb readback", r, {24'b0, exp_cb});
          wait_idle("R4 random ctrlb");
          check("R4 random core_ctrlb", {24'b0, core_ctrlb}, {24'b0, exp_cb});
        end
        1: begin
          apb_wr(A_CTRLA, {30'b0, d[1], 1'b0}); exp_en = d[1];
          wait_idle("R4 random enable");
          check("R4 random core_en", {31'b0, core_en}, {31'b0, exp_en});
        end
        2: begin
          apb_wr(A_CFG + 8'(4 * idx), d);
          if (!exp_en) exp_cfg[idx] = d[15:0];
        end
        default: begin
          apb_rd(A_CFG + 8'(4 * idx), r);
          check("R9 random cfg readback", r, {16'b0, exp_cfg[idx]});
          check("R9 random cfg output", {16'b0, cfg_slice(idx)}, {16'b0, exp_cfg[idx]});
        end
      endcase
    end

    // software reset
    apb_wr(A_CTRLA, 32'h0); wait_idle("R4 pre-reset disable");
    apb_wr(A_CFG, 32'hBEEF);
    apb_wr(A_CTRLB, 32'hC3);
    apb_wr(A_CTRLA, 32'h2); wait_idle("R4 pre-reset enable");
    cclk_run = 0;
    pulse_len = 0;
    apb_wr(A_CTRLA, 32'h1);
    apb_rd(A_STAT, r);  check("R6 reset busy set", r, 32'h1);
    apb_rd(A_CTRLA, r); check("R5 reset bit self clears, R7 enable masked", r, 32'h0);
    apb_rd(A_CTRLB, r); check("R7 ctrlb read refused", r, 32'h0);
    apb_rd(A_CFG, r);   check("R7 cfg read refused", r, 32'h0);
    apb_wr(A_CTRLB, 32'h77);
    apb_wr(A_CTRLA, 32'h0);
    apb_rd(A_STAT, r);  check("R7 writes refused during reset", r, 32'h1);
    repeat (30) @(negedge pclk);
    apb_rd(A_STAT, r);  check("R6 busy held while core clock stopped", r, 32'h1);
    cclk_run = 1;
    wait_idle("R6 reset completes");
    check("R6 core reset length", pulse_len, 32'd4);
    apb_rd(A_CTRLA, r); check("R8 ctrla cleared", r, 32'h0);
    apb_rd(A_CTRLB, r); check("R8 ctrlb cleared", r, 32'h0);
    apb_rd(A_CFG, r);   check("R8 cfg cleared", r, 32'h0);
    check("R8 cfg output cleared", {16'b0, cfg_slice(0)}, 32'h0);
    check("R8 core_en cleared", {31'b0, core_en}, 32'h0);
    check("R8 core_ctrlb cleared", {24'b0, core_ctrlb}, 32'h0);
    apb_wr(A_CTRLB, 32'h11);
    wait_idle("R7 access restored");
    check("R7 ctrlb works after reset", {24'b0, core_ctrlb}, 32'h11);

    // R5 with core clock running
    apb_wr(A_CTRLA, 32'h1);
    apb_rd(A_CTRLA, r); check("R5 reset bit reads 0", r & 32'h1, 32'h0);
    wait_idle("R6 second reset completes");

    finished = 1;
    summary();
    $finish;
  end
endmodule